// File: doc/BRIEF.md
# Block-Scaled Four-Bit Floating-Point Dot-Product Unit

This unit computes the dot product of two vectors whose elements are 4-bit floating-point codes (1 sign bit, 2 exponent bits, 1 mantissa bit). Both vectors are cut into fixed-size groups, and each operand's group carries one shared scale byte. For each group, the unit multiplies the elements pairwise and sums the products exactly in fixed point. It then applies the product of the two group scales once to that partial sum. The scaled result is added to a running total that spans every group of the vector.

A parameter selects one of two group formats. In the first, a group holds 32 elements and each scale is an 8-bit power-of-two exponent with bias 127. This costs 4.25 stored bits per element. In the second, a group holds 16 elements and each scale is a small 8-bit float (1 sign, 4 exponent, 3 mantissa bits). This costs 4.5 stored bits per element.

A `start` pulse clears the total and arms the unit. Groups then arrive one per accepted valid/ready transfer, and the producer flags the final one. The unit drops ready after the final group and raises `done` for one cycle when the total is complete.

Top module: `fp4_block_dot`

## Requirements
- R1: An element code `{s, e[1:0], m}` has magnitude 0.5·m when e = 0, and (1 + 0.5·m)·2^(e−1) otherwise, giving the set {0, 0.5, 1, 1.5, 2, 3, 4, 6}. The sign s negates the value. Both zero codes (0x0 and 0x8) are zero. There are no NaN or Inf codes.
- R2: Element i of a group occupies bits [4i+3:4i] of its operand bus. The in-group sum of products is exact, in units of 1/4, and never leaves ±(group size × 36).
- R3: With FMT_E8 = 1 (32-element groups), the group contributes S·2^(ea+eb−254). Here S is the exact in-group sum, and ea and eb are the unsigned scale bytes.
- R4: With FMT_E8 = 0 (16-element groups), each scale byte is `{sign, exp[3:0], man[2:0]}` with bias 7. It equals (1 + man/8)·2^(exp−7) for exp ≠ 0, and (man/8)·2^(−6) for exp = 0. The group contributes S × scale_a × scale_b.
- R5: `total` is a two's-complement fixed-point value with FRAC_W fraction bits. Each group contribution is floored to that resolution and added modulo 2^ACC_W.
- R6: A `start` pulse clears `total` to zero and raises `in_ready` from the next cycle.
- R7: The group transferred with `in_last` = 1 is the final one. `in_ready` is low from the next cycle until the next `start`, and beats offered while `in_ready` is low leave `total` unchanged.
- R8: On the clock edge after the edge that accepts the final group, `total` holds the complete sum and `done` goes high for exactly one cycle.
- R9: Cycles with `in_valid` low are stalls. They neither lose nor repeat a group, and `total` stays unchanged through them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears the total and arms a new dot product |
| in_valid | input | 1 | A group is offered |
| in_ready | output | 1 | Unit accepts a group |
| in_last | input | 1 | Offered group is the final one |
| a_elems | input | 4·GRP | Packed element codes of operand A |
| b_elems | input | 4·GRP | Packed element codes of operand B |
| a_scale | input | 8 | Group scale of operand A |
| b_scale | input | 8 | Group scale of operand B |
| total | output | ACC_W | Running dot-product total, FRAC_W fraction bits |
| done | output | 1 | One-cycle pulse when the total is complete |

## Verification
The bench runs both group formats side by side and targets these corner cases:

- **Signed zero and subnormal codes.** Pairing a negative zero with a negative half must produce nothing.
- **Smallest scales and flooring.** A sum of −1/4 scaled by the smallest exponents must floor to −1 LSB, not truncate to 0. A design that rounded toward zero would report 0.
- **Largest group.** Every element is at the maximum, which exposes any in-group adder that is too narrow.
- **Scale sign and subnormal scales.** Negative and subnormal float scales are included. Ignoring the scale sign or the implicit one would flip or shift the result.
- **Handshake timing.** Random stalls, plus a junk beat offered just after the final group, catch a unit that counts a group twice, keeps accepting, or raises `done` in the wrong cycle.

// File: rtl/fp4dp_pkg.sv
package fp4dp_pkg;

  // Unsigned magnitude of a 3-bit E2M1 field, in units of one half.
  function automatic logic [3:0] e2m1_halves(input logic [2:0] mag);
    logic [1:0] ex;
    logic       mt;
    ex = mag[2:1];
    mt = mag[0];
    if (ex == 2'd0) begin
      e2m1_halves = {3'b000, mt};
    end else begin
      e2m1_halves = 4'({2'b00, 1'b1, mt} << (ex - 2'd1));
    end
  endfunction

  localparam int unsigned PROD_W  = 9;    // signed quarter-unit product
  localparam int unsigned MAX_PROD = 144; // 12 halves x 12 halves
  localparam int unsigned SH_W    = 11;   // signed shift amount

endpackage

// File: rtl/fp4_lane_mul.sv
module fp4_lane_mul
  import fp4dp_pkg::*;
(
  input  logic [3:0]               a_code,
  input  logic [3:0]               b_code,
  output logic signed [PROD_W-1:0] prod
);
  logic [3:0] ha;
  logic [3:0] hb;
  logic [7:0] mag;
  logic       neg;

  always_comb begin
    ha   = e2m1_halves(a_code[2:0]);
    hb   = e2m1_halves(b_code[2:0]);
    mag  = 8'(ha) * 8'(hb);
    neg  = a_code[3] ^ b_code[3];
    prod = neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  end
endmodule

// File: rtl/fp4_group_sum.sv
module fp4_group_sum
  import fp4dp_pkg::*;
#(
  parameter int unsigned GRP   = 32,
  parameter int unsigned SUM_W = 14
) (
  input  logic [4*GRP-1:0]        a_vec,
  input  logic [4*GRP-1:0]        b_vec,
  output logic signed [SUM_W-1:0] sum
);
  logic signed [PROD_W-1:0] prods [GRP];

  for (genvar g = 0; g < GRP; g++) begin : g_lane
    fp4_lane_mul u_mul (
      .a_code (a_vec[4*g +: 4]),
      .b_code (b_vec[4*g +: 4]),
      .prod   (prods[g])
    );
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < GRP; i++) begin
      sum = sum + SUM_W'(prods[i]);
    end
  end
endmodule

// File: rtl/fp4_scale_apply.sv
module fp4_scale_apply
  import fp4dp_pkg::*;
#(
  parameter bit          FMT_E8 = 1'b1,
  parameter int unsigned SUM_W  = 14,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned FRAC_W = 16
) (
  input  logic signed [SUM_W-1:0] sum,
  input  logic [7:0]              sa,
  input  logic [7:0]              sb,
  output logic signed [ACC_W-1:0] term
);
  localparam int unsigned PW = SUM_W + 9;

  logic signed [ACC_W-1:0] base_ext;
  logic signed [SH_W-1:0]  sh;
  logic [SH_W-1:0]         sh_mag;

  if (FMT_E8) begin : g_e8
    // Pure exponent scales: only the shift changes.
    always_comb begin
      base_ext = ACC_W'(sum);
      sh = $signed({3'b000, sa}) + $signed({3'b000, sb})
           + SH_W'(int'(FRAC_W) - 256);
    end
  end else begin : g_f8
    logic [3:0]             ma, mb;
    logic signed [6:0]      xa, xb;
    logic [7:0]             mprod;
    logic signed [PW-1:0]   s_ext, m_ext, pv;
    always_comb begin
      ma    = {(sa[6:3] != 4'd0), sa[2:0]};
      mb    = {(sb[6:3] != 4'd0), sb[2:0]};
      xa    = $signed({3'b000, (sa[6:3] == 4'd0) ? 4'd1 : sa[6:3]}) - 7'sd10;
      xb    = $signed({3'b000, (sb[6:3] == 4'd0) ? 4'd1 : sb[6:3]}) - 7'sd10;
      mprod = 8'(ma) * 8'(mb);
      s_ext = PW'(sum);
      m_ext = $signed(PW'({1'b0, mprod}));
      pv    = s_ext * m_ext;
      if (sa[7] ^ sb[7]) pv = -pv;
      base_ext = ACC_W'(pv);
      sh = SH_W'(xa) + SH_W'(xb) + SH_W'(int'(FRAC_W) - 2);
    end
  end

  // Arithmetic right shift floors; left shift wraps modulo 2^ACC_W.
  always_comb begin
    if (sh < 0) begin
      sh_mag = SH_W'(-sh);
      term   = base_ext >>> sh_mag;
    end else begin
      sh_mag = sh;
      term   = base_ext << sh_mag;
    end
  end
endmodule

// File: rtl/fp4_block_dot.sv
module fp4_block_dot
  import fp4dp_pkg::*;
#(
  parameter bit          FMT_E8 = 1'b1,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned FRAC_W = 16,
  localparam int unsigned GRP   = FMT_E8 ? 32 : 16,
  localparam int unsigned EW    = 4 * GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  input  logic [EW-1:0]    a_elems,
  input  logic [EW-1:0]    b_elems,
  input  logic [7:0]       a_scale,
  input  logic [7:0]       b_scale,
  output logic [ACC_W-1:0] total,
  output logic             done
);
  localparam int unsigned SUM_W = PROD_W + $clog2(GRP);
  localparam logic signed [SUM_W-1:0] MAX_SUM = SUM_W'(GRP * MAX_PROD);

  logic                    armed_q, armed_d;
  logic                    s1_valid_q, s1_valid_d;
  logic                    s1_last_q;
  logic signed [SUM_W-1:0] s1_sum_q;
  logic [7:0]              s1_sa_q, s1_sb_q;
  logic [ACC_W-1:0]        total_q, total_d;
  logic                    done_q, done_d;
  logic                    fire;
  logic signed [SUM_W-1:0] grp_sum;
  logic signed [ACC_W-1:0] term;

  fp4_group_sum #(.GRP(GRP), .SUM_W(SUM_W)) u_sum (
    .a_vec (a_elems),
    .b_vec (b_elems),
    .sum   (grp_sum)
  );

  fp4_scale_apply #(.FMT_E8(FMT_E8), .SUM_W(SUM_W), .ACC_W(ACC_W),
                    .FRAC_W(FRAC_W)) u_scale (
    .sum  (s1_sum_q),
    .sa   (s1_sa_q),
    .sb   (s1_sb_q),
    .term (term)
  );

  assign fire = in_valid & armed_q;

  always_comb begin
    armed_d = armed_q;
    if (start)                armed_d = 1'b1;
    else if (fire && in_last) armed_d = 1'b0;
    s1_valid_d = fire & ~start;
    total_d = total_q;
    if (start)           total_d = '0;
    else if (s1_valid_q) total_d = total_q + ACC_W'(term);
    done_d = s1_valid_q & s1_last_q & ~start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      s1_valid_q <= 1'b0;
      total_q    <= '0;
      done_q     <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      s1_valid_q <= s1_valid_d;
      total_q    <= total_d;
      done_q     <= done_d;
    end
  end

  // Group stage data, loaded only on an accepted transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_last_q <= 1'b0;
      s1_sum_q  <= '0;
      s1_sa_q   <= '0;
      s1_sb_q   <= '0;
    end else if (fire) begin
      s1_last_q <= in_last;
      s1_sum_q  <= grp_sum;
      s1_sa_q   <= a_scale;
      s1_sb_q   <= b_scale;
    end
  end

  assign in_ready = armed_q;
  assign total    = total_q;
  assign done     = done_q;

  // R2
  sum_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid_q |-> (s1_sum_q <= MAX_SUM && s1_sum_q >= -MAX_SUM));
  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (total == '0 && in_ready));
  // R7
  last_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && !start) |=> !in_ready);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_ready && in_last, 2));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !s1_valid_q) |=> $stable(total));
endmodule

// File: tb/tb_fp4_block_dot.sv
module tb_fp4_block_dot;
  localparam int ACC_W = 48;
  localparam int FRAC_W = 16;
  localparam logic [63:0] MASK = (64'd1 << ACC_W) - 64'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [127:0] a32 = '0, b32 = '0;
  logic [7:0] sa = '0, sb = '0;
  logic rdy32, rdy16, done32, done16;
  logic [ACC_W-1:0] tot32, tot16;

  int checks = 0, errors = 0;
  int ac[32], bc[32];
  longint exp32, exp16;
  bit finished = 0;

  always #4 clk = ~clk;

  fp4_block_dot #(.FMT_E8(1'b1), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(rdy32), .in_last(in_last), .a_elems(a32), .b_elems(b32),
    .a_scale(sa), .b_scale(sb), .total(tot32), .done(done32));

  fp4_block_dot #(.FMT_E8(1'b0), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) dut16 (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_ready(rdy16), .in_last(in_last), .a_elems(a32[63:0]),
    .b_elems(b32[63:0]), .a_scale(sa), .b_scale(sb), .total(tot16),
    .done(done16));

  task automatic chk(string req, logic [63:0] got, logic [63:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, want);
    end
  endtask

  // R1: element value in halves
  function automatic int halves(int c);
    int e, m, v;
    e = (c >> 1) & 3;
    m = c & 1;
    v = (e == 0) ? m : ((2 + m) << (e - 1));
    return ((c & 8) != 0) ? -v : v;
  endfunction

  function automatic longint gsum(int n);
    longint s = 0;
    for (int i = 0; i < n; i++) s += halves(ac[i]) * halves(bc[i]);
    return s;
  endfunction

  function automatic longint shf(longint v, int sh);
    return (sh >= 0) ? (v <<< sh) : (v >>> (-sh));
  endfunction

  // R3
  function automatic longint term_e8(longint s, int ea, int eb);
    return shf(s, ea + eb - 256 + FRAC_W);
  endfunction

  // R4
  function automatic longint term_f8(longint s, int ea, int eb);
    int ma, mb, xa, xb;
    longint p;
    ma = (((ea >> 3) & 15) != 0) ? 8 + (ea & 7) : (ea & 7);
    mb = (((eb >> 3) & 15) != 0) ? 8 + (eb & 7) : (eb & 7);
    xa = ((((ea >> 3) & 15) != 0) ? ((ea >> 3) & 15) : 1) - 10;
    xb = ((((eb >> 3) & 15) != 0) ? ((eb >> 3) & 15) : 1) - 10;
    p = s * ma * mb;
    if (((ea ^ eb) & 128) != 0) p = -p;
    return shf(p, xa + xb - 2 + FRAC_W);
  endfunction

  // kind 0 random, 1 max elements, 2 signed zero/floor, 3 negative scale
  task automatic load_group(int kind);
    for (int i = 0; i < 32; i++) begin
      case (kind)
        1: begin ac[i] = 7; bc[i] = 7; end
        2: begin ac[i] = 8; bc[i] = 9; end
        default: begin ac[i] = int'($urandom % 16); bc[i] = int'($urandom % 16); end
      endcase
    end
    case (kind)
      1: begin sa = 8'd127; sb = 8'd127; end
      2: begin ac[0] = 1; bc[0] = 9; sa = 8'd0; sb = 8'd0; end
      3: begin sa = 8'h88; sb = 8'h38; end
      default: begin sa = 8'(110 + $urandom % 31); sb = 8'(110 + $urandom % 31); end
    endcase
    for (int i = 0; i < 32; i++) begin
      a32[4*i +: 4] = 4'(ac[i]);
      b32[4*i +: 4] = 4'(bc[i]);
    end
    exp32 += term_e8(gsum(32), int'(sa), int'(sb));
    exp16 += term_f8(gsum(16), int'(sa), int'(sb));
  endtask

  task automatic run(int ngroups, int kind, bit bubbles);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    exp32 = 0; exp16 = 0;
    chk("R6 ready after start", {63'd0, rdy32 & rdy16}, 64'd1);
    chk("R6 total cleared 32", 64'(tot32), 64'd0);
    chk("R6 total cleared 16", 64'(tot16), 64'd0);
    for (int g = 0; g < ngroups; g++) begin
      if (bubbles && ($urandom % 3 == 0)) begin
        @(negedge clk);
        @(negedge clk);
      end
      load_group(kind);
      in_valid = 1'b1;
      in_last = (g == ngroups - 1);
      @(negedge clk) in_valid = 1'b0;
    end
    chk("R7 ready low after last", {63'd0, rdy32 | rdy16}, 64'd0);
    // junk beat offered while not ready
    a32 = {4{$urandom}}; b32 = {4{$urandom}}; sa = 8'd127; sb = 8'd127;
    in_valid = 1'b1; in_last = 1'b1;
    @(negedge clk) in_valid = 1'b0; in_last = 1'b0;
    chk("R8 done 32", {63'd0, done32}, 64'd1);
    chk("R8 done 16", {63'd0, done16}, 64'd1);
    chk("R1 R2 R3 R5 total 32", 64'(tot32), 64'(exp32) & MASK);
    chk("R1 R2 R4 R5 total 16", 64'(tot16), 64'(exp16) & MASK);
    @(negedge clk);
    chk("R8 done drops", {63'd0, done32 | done16}, 64'd0);
    chk("R7 R9 total held 32", 64'(tot32), 64'(exp32) & MASK);
    chk("R7 R9 total held 16", 64'(tot16), 64'(exp16) & MASK);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("reset ready", {63'd0, rdy32 | rdy16}, 64'd0);
    chk("reset done", {63'd0, done32 | done16}, 64'd0);
    chk("reset total", 64'(tot32) | 64'(tot16), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    run(1, 1, 0);   // R2 largest group
    run(1, 2, 0);   // R1 signed zero, R5 floor to -1 LSB
    run(2, 3, 0);   // R4 negative scale
    run(3, 2, 1);
    for (int r = 0; r < 10; r++) run(1 + int'($urandom % 6), 0, 1); // R9 stalls
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule